// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block lets a host processor reach the configuration registers of devices on a shared parallel bus through two fixed I/O ports. Port 0x0CF8 holds a pointer register that names a device slot, a function and a doubleword register. Port 0x0CFC is a data window. A host access to that window, made while the pointer has its enable bit set, becomes one bus configuration cycle in which the bridge is the initiator. That cycle has a single address phase and a single data phase. Read data, or the master-abort fill value, goes back to the host. A write is simply completed.

Host requests arrive on a valid/ready stream. The bridge raises `req_ready` only when it is idle, so a data-window access made while a bus cycle is in progress stays stalled. Every accepted request yields exactly one beat on the response stream. That beat stays on the port, unchanged, until the host accepts it with `rsp_ready`. While the beat is waiting, no new request is accepted. This back-pressure is the only flow control on the host side. The bus signals are active low, except `ad_oe` and `idsel`.

Top module: `hostcfg_bridge`

## Requirements
- R1: Out of reset the state is as follows. `frame_n`, `irdy_n` and every `cbe_n` bit are high. `idsel` is all zero and `ad_oe` is low. `req_ready` is high and `rsp_valid` is low. The pointer register reads back as 0.
- R2: A write to port 0x0CF8 loads the pointer register. Bit 31 is the enable, bits 15:11 are the device slot, bits 10:8 are the function and bits 7:2 are the register number. A read of 0x0CF8 returns those fields with all other bits zero.
- R3: A data-window access made while enable is clear starts no bus cycle. It reads back 0xFFFFFFFF, and a write answers 0. An access to any port other than the two fixed ones reads 0xFFFFFFFF, and a write to such a port leaves the pointer unchanged.
- R4: An enabled data-window access produces one address-phase cycle. In that cycle `frame_n` is low and `ad_out` is driven with {21'b0, function, register, 2'b00}. `cbe_n` carries 4'b1010 for a read or 4'b1011 for a write. In the next cycle `frame_n` is high and `irdy_n` is low.
- R5: During the address phase only, `idsel` bit N is set, where N is the slot number when that number is below the slot count. A slot number outside that range sets no bit.
- R6: During the data phase `cbe_n` equals the inverted host byte lanes `req_be`. A write drives `req_wdata` on `ad_out` with `ad_oe` high. A read leaves `ad_oe` low.
- R7: The data phase ends at the first rising edge where both `irdy_n` and `trdy_n` are low. `irdy_n` stays low through target wait states and is released in the cycle after that edge. A read returns the `ad_in` value sampled at that edge.
- R8: If `devsel_n` is not seen low at any of the first 5 data-phase edges, the bridge ends the cycle (master abort). A read then returns 0xFFFFFFFF and write data is dropped. A `devsel_n` that goes low on the fifth edge still counts, and once `devsel_n` has been seen there is no limit on target wait states.
- R9: `req_ready` is low from the accepting edge until the response is taken. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold.
- R10: Each accepted request yields exactly one response beat. Every write answers with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can accept a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 16 | Host I/O port number |
| req_wdata | input | 32 | Host write data |
| req_be | input | 4 | Host byte lanes, active high |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Host takes the response beat |
| rsp_rdata | output | 32 | Response data |
| frame_n | output | 1 | Bus frame, low in the address phase |
| irdy_n | output | 1 | Initiator ready, low in the data phase |
| ad_out | output | 32 | Address/data driven by the bridge |
| ad_oe | output | 1 | Bridge drives the address/data lines |
| ad_in | input | 32 | Address/data driven by the target |
| cbe_n | output | 4 | Command / byte enables, active low |
| idsel | output | 8 | Per-slot configuration select, one-hot |
| devsel_n | input | 1 | Target claims the cycle |
| trdy_n | input | 1 | Target ready |

## Verification
The bound checker watches the bus signals on every cycle. It confirms that each address phase lasts one cycle and is followed by the data phase, and that each address phase puts a doubleword address on the lines. It confirms that `idsel` is one-hot and only active in the address phase, and that `irdy_n` is held through wait states and released after a transfer. It uses a counter of the data-phase edges to confirm the 5-edge abort limit, and it checks the stall and hold rules of the host handshake. The bench scenarios are what show the data path. They compare the decoded field values on `ad_out`, and show that a disabled pointer or a foreign port launches no cycle. They also cover read data and the all-ones fill on abort, the exact devsel boundary at the fifth edge, and long wait states after devsel, all through the scoreboard of expected response beats.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  localparam logic [3:0]       CMD_CFG_RD = 4'b1010;
  localparam logic [3:0]       CMD_CFG_WR = 4'b1011;
  localparam logic [BUS_W-1:0] FILL_ONES  = '1;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ADDR, SQ_DATA} seq_state_t;
  typedef enum logic [1:0] {FE_IDLE, FE_BUS, FE_RESP} fe_state_t;

  typedef struct packed {
    logic       en;
    logic [4:0] slot;
    logic [2:0] func;
    logic [5:0] regno;
  } cfg_ptr_t;

  function automatic logic [BUS_W-1:0] ptr_readback(cfg_ptr_t p);
    return {p.en, 15'b0, p.slot, p.func, p.regno, 2'b00};
  endfunction

endpackage

// File: rtl/cfgb_ptr_reg.sv
module cfgb_ptr_reg
  import cfgb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wdata,
  output cfg_ptr_t         ptr
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[30:16], wdata[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_en) begin
      ptr.en    <= wdata[31];
      ptr.slot  <= wdata[15:11];
      ptr.func  <= wdata[10:8];
      ptr.regno <= wdata[7:2];
    end
  end
endmodule

// File: rtl/cfgb_phase_build.sv
module cfgb_phase_build
  import cfgb_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  cfg_ptr_t             ptr,
  input  logic                 is_write,
  output logic [BUS_W-1:0]     addr_word,
  output logic [3:0]           cmd,
  output logic [NUM_SLOTS-1:0] idsel_vec
);
  assign addr_word = {{(BUS_W-11){1'b0}}, ptr.func, ptr.regno, 2'b00};
  assign cmd       = is_write ? CMD_CFG_WR : CMD_CFG_RD;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
    assign idsel_vec[i] = (ptr.slot == 5'(i));
  end
endmodule

// File: rtl/cfgb_cycle_seq.sv
module cfgb_cycle_seq
  import cfgb_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int TIMEOUT   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 is_write,
  input  logic [BUS_W-1:0]     wdata,
  input  logic [LANES-1:0]     be,
  input  logic [BUS_W-1:0]     addr_word,
  input  logic [3:0]           cmd,
  input  logic [NUM_SLOTS-1:0] idsel_vec,
  input  logic                 devsel_n,
  input  logic                 trdy_n,
  input  logic [BUS_W-1:0]     ad_in,
  output logic                 done,
  output logic [BUS_W-1:0]     rdata,
  output logic                 frame_n,
  output logic                 irdy_n,
  output logic [BUS_W-1:0]     ad_out,
  output logic                 ad_oe,
  output logic [3:0]           cbe_n,
  output logic [NUM_SLOTS-1:0] idsel
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(TIMEOUT - 1);

  seq_state_t             st;
  logic [CNT_W-1:0]       edge_cnt;
  logic                   dev_seen;
  logic                   wr_q;
  logic [BUS_W-1:0]       wdata_q;
  logic [BUS_W-1:0]       addr_q;
  logic [LANES-1:0]       be_q;
  logic [3:0]             cmd_q;
  logic [NUM_SLOTS-1:0]   idsel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      edge_cnt <= '0;
      dev_seen <= 1'b0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      addr_q   <= '0;
      be_q     <= '0;
      cmd_q    <= '0;
      idsel_q  <= '0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            wr_q    <= is_write;
            wdata_q <= wdata;
            addr_q  <= addr_word;
            be_q    <= be;
            cmd_q   <= cmd;
            idsel_q <= idsel_vec;
            st      <= SQ_ADDR;
          end
        end
        SQ_ADDR: begin
          edge_cnt <= '0;
          dev_seen <= 1'b0;
          st       <= SQ_DATA;
        end
        SQ_DATA: begin
          if (!trdy_n) begin
            done  <= 1'b1;
            rdata <= wr_q ? '0 : ad_in;
            st    <= SQ_IDLE;
          end else if (!devsel_n) begin
            dev_seen <= 1'b1;
          end else if (!dev_seen && edge_cnt == LAST_EDGE) begin
            done  <= 1'b1;
            rdata <= wr_q ? '0 : FILL_ONES;
            st    <= SQ_IDLE;
          end else if (!dev_seen) begin
            edge_cnt <= edge_cnt + CNT_W'(1);
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    frame_n = 1'b1;
    irdy_n  = 1'b1;
    ad_out  = '0;
    ad_oe   = 1'b0;
    cbe_n   = 4'hF;
    idsel   = '0;
    case (st)
      SQ_ADDR: begin
        frame_n = 1'b0;
        ad_out  = addr_q;
        ad_oe   = 1'b1;
        cbe_n   = cmd_q;
        idsel   = idsel_q;
      end
      SQ_DATA: begin
        irdy_n = 1'b0;
        cbe_n  = ~be_q;
        if (wr_q) begin
          ad_out = wdata_q;
          ad_oe  = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hostcfg_bridge.sv
module hostcfg_bridge
  import cfgb_pkg::*;
#(
  parameter int             PORT_W    = 16,
  parameter logic [15:0]    PTR_PORT  = 16'h0CF8,
  parameter logic [15:0]    WIN_PORT  = 16'h0CFC,
  parameter int             NUM_SLOTS = 8,
  parameter int             TIMEOUT   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [PORT_W-1:0]    req_port,
  input  logic [31:0]          req_wdata,
  input  logic [3:0]           req_be,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [31:0]          rsp_rdata,
  output logic                 frame_n,
  output logic                 irdy_n,
  output logic [31:0]          ad_out,
  output logic                 ad_oe,
  input  logic [31:0]          ad_in,
  output logic [3:0]           cbe_n,
  output logic [NUM_SLOTS-1:0] idsel,
  input  logic                 devsel_n,
  input  logic                 trdy_n
);
  fe_state_t            fe;
  cfg_ptr_t             ptr;
  logic                 accept, hit_ptr, hit_win, launch, ptr_wr;
  logic [BUS_W-1:0]     local_rsp, rsp_q, addr_word, seq_rdata;
  logic [3:0]           cmd;
  logic [NUM_SLOTS-1:0] idsel_vec;
  logic                 seq_done;

  assign req_ready = (fe == FE_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit_ptr   = (req_port == PORT_W'(PTR_PORT));
  assign hit_win   = (req_port == PORT_W'(WIN_PORT));
  assign ptr_wr    = accept && hit_ptr && req_write;
  assign launch    = accept && hit_win && ptr.en;

  always_comb begin
    if (req_write)    local_rsp = '0;
    else if (hit_ptr) local_rsp = ptr_readback(ptr);
    else              local_rsp = FILL_ONES;
  end

  cfgb_ptr_reg i_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(ptr_wr), .wdata(req_wdata), .ptr(ptr)
  );

  cfgb_phase_build #(.NUM_SLOTS(NUM_SLOTS)) i_build (
    .ptr(ptr), .is_write(req_write), .addr_word(addr_word), .cmd(cmd),
    .idsel_vec(idsel_vec)
  );

  cfgb_cycle_seq #(.NUM_SLOTS(NUM_SLOTS), .TIMEOUT(TIMEOUT)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(launch), .is_write(req_write),
    .wdata(req_wdata), .be(req_be), .addr_word(addr_word), .cmd(cmd),
    .idsel_vec(idsel_vec), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .ad_in(ad_in), .done(seq_done), .rdata(seq_rdata), .frame_n(frame_n),
    .irdy_n(irdy_n), .ad_out(ad_out), .ad_oe(ad_oe), .cbe_n(cbe_n),
    .idsel(idsel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fe    <= FE_IDLE;
      rsp_q <= '0;
    end else begin
      case (fe)
        FE_IDLE: if (accept) begin
          if (launch) begin
            fe <= FE_BUS;
          end else begin
            rsp_q <= local_rsp;
            fe    <= FE_RESP;
          end
        end
        FE_BUS: if (seq_done) begin
          rsp_q <= seq_rdata;
          fe    <= FE_RESP;
        end
        FE_RESP: if (rsp_ready) fe <= FE_IDLE;
        default: fe <= FE_IDLE;
      endcase
    end
  end

  assign rsp_valid = (fe == FE_RESP);
  assign rsp_rdata = rsp_q;
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker #(
  parameter int NUM_SLOTS = 8,
  parameter int TIMEOUT   = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_n,
  input logic                 irdy_n,
  input logic                 devsel_n,
  input logic                 trdy_n,
  input logic [31:0]          ad_out,
  input logic                 ad_oe,
  input logic [NUM_SLOTS-1:0] idsel,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [31:0]          rsp_rdata
);
  logic [15:0] wait_cnt;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      seen_q   <= 1'b0;
    end else if (!frame_n) begin
      wait_cnt <= '0;
      seen_q   <= 1'b0;
    end else if (!irdy_n) begin
      if (wait_cnt != 16'hFFFF) wait_cnt <= wait_cnt + 16'd1;
      if (!devsel_n) seen_q <= 1'b1;
    end
  end

  AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> frame_n); // R4
  AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !irdy_n); // R4
  AST_ADDR_DWORD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> (ad_oe && ad_out[1:0] == 2'b00)); // R4
  AST_IDSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(idsel)); // R5
  AST_IDSEL_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (idsel != '0) |-> !frame_n); // R5
  AST_IRDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !trdy_n) |=> irdy_n); // R7
  AST_IRDY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && trdy_n && !devsel_n) |=> !irdy_n); // R7
  AST_ABORT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(!irdy_n && !seen_q && wait_cnt >= 16'(TIMEOUT))); // R8
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n || !irdy_n) |-> !req_ready); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R9
endmodule

bind hostcfg_bridge cfgb_checker #(.NUM_SLOTS(NUM_SLOTS), .TIMEOUT(TIMEOUT)) i_cfgb_checker (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .devsel_n(devsel_n), .trdy_n(trdy_n), .ad_out(ad_out), .ad_oe(ad_oe),
  .idsel(idsel), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
);

// File: tb/test_hostcfg_bridge.sv
module test_hostcfg_bridge;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [15:0] req_port = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        frame_n, irdy_n, ad_oe;
  logic [31:0] ad_out, ad_in = '0;
  logic [3:0]  cbe_n;
  logic [7:0]  idsel;
  logic        devsel_n = 1'b1, trdy_n = 1'b1;

  hostcfg_bridge i_hostcfg_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_port(req_port), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .cbe_n(cbe_n),
    .idsel(idsel), .devsel_n(devsel_n), .trdy_n(trdy_n)
  );

  typedef struct packed {
    logic [31:0] ad;
    logic [3:0]  cmd;
    logic [7:0]  sel;
    logic        wr;
    logic [31:0] wd;
    logic [3:0]  be;
  } bus_item_t;

  logic [31:0] rsp_q[$];
  string       tag_q[$];
  bus_item_t   bus_q[$];
  bus_item_t   cur;
  int n_cmp = 0, n_bad = 0;
  int frames = 0, tcnt = 0, dv_lat = 1, tr_lat = 1;
  logic tgt_act = 1'b0;
  logic [31:0] rd_val = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor on the response stream
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (rsp_q.size() == 0) check("R10 unexpected beat", rsp_rdata, 32'hX);
      else check(tag_q.pop_front(), rsp_rdata, rsp_q.pop_front());
    end
  end

  // bus target model
  always @(negedge clk) begin
    if (!rst_n) begin
      tgt_act = 1'b0;
    end else if (!frame_n) begin
      frames++;
      tgt_act = 1'b1;
      tcnt = 0;
      if (bus_q.size() == 0) begin
        check("R3 unexpected address phase", ad_out, 32'hX);
      end else begin
        cur = bus_q.pop_front();
        check("R4 address word", ad_out, cur.ad);
        check("R4 address drive", {31'b0, ad_oe}, 32'd1);
        check("R4 command", {28'b0, cbe_n}, {28'b0, cur.cmd});
        check("R5 idsel", {24'b0, idsel}, {24'b0, cur.sel});
      end
    end else if (tgt_act && !irdy_n) begin
      tcnt++;
      if (tcnt >= dv_lat) devsel_n = 1'b0;
      if (tcnt >= tr_lat) begin
        trdy_n = 1'b0;
        ad_in  = rd_val;
        check("R6 byte enables", {28'b0, cbe_n}, {28'b0, ~cur.be});
        check("R6 data drive", {31'b0, ad_oe}, {31'b0, cur.wr});
        if (cur.wr) check("R6 write data", ad_out, cur.wd);
      end
    end else if (tgt_act) begin
      tgt_act  = 1'b0;
      devsel_n = 1'b1;
      trdy_n   = 1'b1;
      ad_in    = '0;
    end
  end

  task automatic host_op(input logic [15:0] port, input logic wr, input logic [31:0] wd,
                         input logic [3:0] be, input logic [31:0] exp, input string tag,
                         input int hold);
    rsp_q.push_back(exp);
    tag_q.push_back(tag);
    req_port = port; req_write = wr; req_wdata = wd; req_be = be;
    req_valid = 1'b1;
    rsp_ready = (hold == 0);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1 req_valid = 1'b0;
    if (hold > 0) begin
      do @(negedge clk); while (!rsp_valid);
      for (int k = 0; k < hold; k++) begin
        check("R9 rsp held", {31'b0, rsp_valid}, 32'd1);
        check("R9 rsp data stable", rsp_rdata, exp);
        check("R9 stall while pending", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
      end
      @(posedge clk); #1 rsp_ready = 1'b1;
    end
    while (rsp_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic cfg_op(input logic wr, input int slot, input int func, input int regno,
                        input logic [3:0] be, input logic [31:0] wd, input int dvl,
                        input int trl, input logic [31:0] rval, input logic [31:0] exp,
                        input string tag, input int hold);
    bus_item_t it;
    int f0;
    host_op(16'h0CF8, 1'b1, {1'b1, 15'b0, slot[4:0], func[2:0], regno[5:0], 2'b00},
            4'hF, 32'h0, "R10 pointer write", 0);
    it.ad  = {21'b0, func[2:0], regno[5:0], 2'b00};
    it.cmd = wr ? 4'b1011 : 4'b1010;
    it.sel = (slot < 8) ? (8'd1 << slot) : 8'd0;
    it.wr  = wr; it.wd = wd; it.be = be;
    bus_q.push_back(it);
    dv_lat = dvl; tr_lat = trl; rd_val = rval;
    f0 = frames;
    host_op(16'h0CFC, wr, wd, be, exp, tag, hold);
    check("R4 one cycle per access", frames - f0, 1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 frame idle", {31'b0, frame_n}, 32'd1);
    check("R1 irdy idle", {31'b0, irdy_n}, 32'd1);
    check("R1 cbe idle", {28'b0, cbe_n}, 32'hF);
    check("R1 idsel idle", {24'b0, idsel}, 32'd0);
    check("R1 no drive", {31'b0, ad_oe}, 32'd0);
    check("R1 ready", {31'b0, req_ready}, 32'd1);
    check("R1 no response", {31'b0, rsp_valid}, 32'd0);
    @(posedge clk); #1;
    host_op(16'h0CF8, 1'b0, 0, 4'hF, 32'h0, "R1 pointer reset value", 0);

    // R2 pointer field masking
    host_op(16'h0CF8, 1'b1, 32'hFFFF_FFFF, 4'hF, 32'h0, "R10 write answers 0", 0);
    host_op(16'h0CF8, 1'b0, 0, 4'hF, 32'h8000_FFFC, "R2 readback mask", 0);
    host_op(16'h0CF8, 1'b1, 32'h7FFF_1A07, 4'hF, 32'h0, "R10 write answers 0", 0);
    host_op(16'h0CF8, 1'b0, 0, 4'hF, 32'h0000_1A04, "R2 readback fields", 0);

    // R3 disabled window and foreign ports
    f0 = frames;
    host_op(16'h0CFC, 1'b0, 0, 4'hF, 32'hFFFF_FFFF, "R3 disabled read", 0);
    host_op(16'h0CFC, 1'b1, 32'h1234_5678, 4'hF, 32'h0, "R3 disabled write", 0);
    host_op(16'h0080, 1'b1, 32'h8000_0000, 4'hF, 32'h0, "R3 foreign write", 0);
    host_op(16'h0080, 1'b0, 0, 4'hF, 32'hFFFF_FFFF, "R3 foreign read", 0);
    host_op(16'h0CF8, 1'b0, 0, 4'hF, 32'h0000_1A04, "R3 pointer untouched", 0);
    check("R3 no bus cycle", frames - f0, 0);

    // R4 R5 R7 plain read
    cfg_op(1'b0, 2, 3, 5, 4'hF, 0, 1, 1, 32'hA5A5_1234, 32'hA5A5_1234, "R7 read data", 0);
    // R6 R7 write with wait states
    cfg_op(1'b1, 7, 0, 63, 4'b0101, 32'hDEAD_BEEF, 2, 4, 0, 32'h0, "R6 write response", 0);
    // R7 wait beyond the abort window once claimed
    cfg_op(1'b0, 0, 7, 1, 4'b0011, 0, 2, 9, 32'h0BAD_F00D, 32'h0BAD_F00D, "R7 long wait read", 0);
    // R8 boundary: claim on the fifth edge
    cfg_op(1'b0, 4, 1, 16, 4'hF, 0, 5, 5, 32'h1357_9BDF, 32'h1357_9BDF, "R8 claim at edge 5", 0);
    // R8 no claim: master abort
    cfg_op(1'b0, 5, 2, 8, 4'hF, 0, 6, 6, 32'h2468_ACE0, 32'hFFFF_FFFF, "R8 abort read", 0);
    cfg_op(1'b1, 1, 0, 0, 4'hF, 32'hCAFE_0001, 99, 99, 0, 32'h0, "R8 abort write", 0);
    // R5 slot outside range -> no select, abort
    cfg_op(1'b0, 9, 0, 2, 4'hF, 0, 99, 99, 0, 32'hFFFF_FFFF, "R5 no slot abort", 0);
    // R9 back-pressure on the response
    cfg_op(1'b0, 3, 4, 12, 4'hF, 0, 1, 2, 32'h7777_0042, 32'h7777_0042, "R9 held read", 6);

    check("R10 scoreboard drained", rsp_q.size(), 0);
    check("R4 bus items drained", bus_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule